// File: doc/BRIEF.md
# Set-Associative Tag Lookup with LRU Replacement

This block is the tag side of a level-one data cache that holds 32 KB as 512 lines of 64 bytes. The lines are arranged as 64 sets of 8 ways, and the cache is addressed by a 36-bit physical address. For each accepted request it takes the set number and the tag from the address. It then reads the valid bits and tags of all eight ways of that set and compares the eight tags in the same cycle. The result is a hit, with the way that holds the line, or a miss. The data array sits beside this block and uses the reported way.

On a miss the block picks a way to replace. An empty way is taken first. When the set is full, the least recently used way is taken. The block asks the next level for the whole line through a request/acknowledge pair and stalls new requests until the acknowledge arrives. The new tag is written into the chosen way at that point, and the access then completes as a miss that names the filled way. A flush input empties the cache by clearing one set per cycle.

Top module: `l1tag_lookup`

## Requirements
- R1: The address is decoded as tag = bits [35:12], set = bits [11:6] and byte offset = bits [5:0]. The offset never affects hit or miss. The line address issued on a miss is the request address with bits [5:0] forced to zero.
- R2: A request is a hit only when a way of the indexed set is valid and its stored tag equals the request tag. One cycle after acceptance, resp_valid=1, resp_hit=1 and resp_way gives the matching way (0 to 7).
- R3: On a miss, fill_req rises one cycle after acceptance and stays high until fill_ack is sampled high. One cycle after that acknowledge, resp_valid=1, resp_hit=0 and resp_way gives the filled way. A later request to the same line then hits in that way.
- R4: Only one miss is outstanding at a time. req_ready is low from the cycle after a miss is accepted through the acknowledge cycle, and no request or response occurs in that window.
- R5: The 64 consecutive lines of a 4 KB page go to the 64 different sets, so a whole page can be resident at the same time.
- R6: When the indexed set has an invalid way, the victim is the lowest-numbered invalid way, whatever the recency order.
- R7: When all eight ways are valid, the victim is the way whose last hit or fill is the oldest. Both hits and fills make a way the most recently used.
- R8: A flush sets flush_busy for exactly 64 cycles, starting one cycle after the flush is sampled, and clears one set per cycle. req_ready is low throughout. Afterwards every line misses, including a line whose tag is still stored.
- R9: A flush is taken only while idle and wins over a request in the same cycle. req_ready is low whenever flush is high, so that request is not accepted and produces no response.
- R10: After reset, req_ready=1, resp_valid=0, fill_req=0 and flush_busy=0, and every way of every set is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lookup request is presented |
| req_addr | input | 36 | Physical byte address of the request |
| req_ready | output | 1 | The block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle pulse marking a completed access |
| resp_hit | output | 1 | 1 for a hit, 0 for an access completed by a fill |
| resp_way | output | 3 | Way that holds the line |
| fill_req | output | 1 | Line fill requested from the next level |
| fill_addr | output | 36 | Line-aligned address of the fill |
| fill_ack | input | 1 | Next level has delivered the line |
| flush | input | 1 | Start invalidating every line |
| flush_busy | output | 1 | Flush sweep in progress |

## Verification
The assertions rely on a few properties of the inputs. fill_ack must come only while fill_req is high. A flush is taken only in the idle state, so a fill write and a set clear never fall in the same cycle. Tags within one set must never be duplicated, which holds because a tag is installed only after a miss. The bench keeps to these rules by raising fill_ack for a single cycle while a miss is pending, and by starting a flush only when req_ready was high in the previous cycle. It also places a blocked probe request during every pending fill to show that the stall holds.

// File: rtl/l1tag_pkg.sv
package l1tag_pkg;
  localparam int ADDR_W = 36;
  localparam int OFF_W  = 6;
  localparam int SET_W  = 6;
  localparam int WAY_W  = 3;
  localparam int WAYS   = 1 << WAY_W;
  localparam int SETS   = 1 << SET_W;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [SET_W-1:0]  set_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [WAYS-1:0]   wmask_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MISS, ST_FLUSH} state_e;

  function automatic tag_t addr_tag(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic set_t addr_set(addr_t a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic addr_t line_addr(tag_t t, set_t s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // lowest set bit of a way mask; zero when the mask is empty
  function automatic way_t first_one(wmask_t v);
    way_t r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) r = way_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/l1tag_store.sv
module l1tag_store
  import l1tag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  set_t   rd_set,
  input  tag_t   rd_tag,
  output wmask_t hit_vec,
  output wmask_t set_valid,
  input  logic   wr_en,
  input  set_t   wr_set,
  input  way_t   wr_way,
  input  tag_t   wr_tag,
  input  logic   clr_en,
  input  set_t   clr_set
);
  tag_t   tag_q   [SETS][WAYS];
  wmask_t valid_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (clr_en) valid_q[clr_set] <= '0;
      if (wr_en)  valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  assign set_valid = valid_q[rd_set];

  // eight comparators working on the same set in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_valid[w] && (tag_q[rd_set][w] == rd_tag);
  end

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_clear_whole_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (valid_q[$past(clr_set)] == '0));

  p_fill_marks_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/l1tag_lru.sv
module l1tag_lru
  import l1tag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  set_t   look_set,
  input  wmask_t look_valid,
  output way_t   victim,
  input  logic   touch_en,
  input  set_t   touch_set,
  input  way_t   touch_way
);
  // per-set age ranks: 0 = most recent, WAYS-1 = oldest; always a permutation
  way_t   age_q [SETS][WAYS];
  way_t   look_age [WAYS];
  wmask_t oldest_vec;
  way_t   touch_age;

  always_comb begin
    for (int w = 0; w < WAYS; w++) look_age[w] = age_q[look_set][w];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (look_age[w] == way_t'(WAYS - 1));
  end

  assign victim    = (&look_valid) ? first_one(oldest_vec) : first_one(~look_valid);
  assign touch_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= way_t'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_t'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < touch_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + way_t'(1);
      end
    end
  end

  p_touch_youngest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[$past(touch_set)][$past(touch_way)] == '0));

  p_one_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/l1tag_ctrl.sv
module l1tag_ctrl
  import l1tag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  addr_t req_addr,
  output logic  req_ready,
  input  logic  hit_any,
  input  way_t  hit_way,
  input  way_t  victim,
  input  logic  flush,
  output logic  flush_busy,
  input  logic  fill_ack,
  output logic  fill_req,
  output addr_t fill_addr,
  output logic  resp_valid,
  output logic  resp_hit,
  output way_t  resp_way,
  output logic  wr_en,
  output set_t  wr_set,
  output way_t  wr_way,
  output tag_t  wr_tag,
  output logic  clr_en,
  output set_t  clr_set,
  output logic  touch_en,
  output set_t  touch_set,
  output way_t  touch_way
);
  state_e state_q;
  tag_t   miss_tag_q;
  set_t   miss_set_q;
  way_t   miss_way_q;
  set_t   sweep_q;
  logic   resp_valid_q, resp_hit_q;
  way_t   resp_way_q;

  // named internal events
  logic accept, acc_hit, acc_miss, fill_done, flush_start, sweep_last;

  assign req_ready   = (state_q == ST_IDLE) && !flush;
  assign accept      = req_valid && req_ready;
  assign acc_hit     = accept && hit_any;
  assign acc_miss    = accept && !hit_any;
  assign flush_start = (state_q == ST_IDLE) && flush;
  assign fill_done   = (state_q == ST_MISS) && fill_ack;
  assign sweep_last  = (sweep_q == set_t'(SETS - 1));

  assign fill_req   = (state_q == ST_MISS);
  assign fill_addr  = line_addr(miss_tag_q, miss_set_q);
  assign flush_busy = (state_q == ST_FLUSH);

  assign wr_en  = fill_done;
  assign wr_set = miss_set_q;
  assign wr_way = miss_way_q;
  assign wr_tag = miss_tag_q;

  assign clr_en  = (state_q == ST_FLUSH);
  assign clr_set = sweep_q;

  assign touch_en  = acc_hit || fill_done;
  assign touch_set = fill_done ? miss_set_q : addr_set(req_addr);
  assign touch_way = fill_done ? miss_way_q : hit_way;

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_way   = resp_way_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      miss_tag_q   <= '0;
      miss_set_q   <= '0;
      miss_way_q   <= '0;
      sweep_q      <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_way_q   <= '0;
    end else begin
      resp_valid_q <= acc_hit || fill_done;
      resp_hit_q   <= acc_hit;
      resp_way_q   <= acc_hit ? hit_way : miss_way_q;
      unique case (state_q)
        ST_IDLE: begin
          if (flush_start) begin
            state_q <= ST_FLUSH;
            sweep_q <= '0;
          end else if (acc_miss) begin
            state_q    <= ST_MISS;
            miss_tag_q <= addr_tag(req_addr);
            miss_set_q <= addr_set(req_addr);
            miss_way_q <= victim;
          end
        end
        ST_MISS: begin
          if (fill_ack) state_q <= ST_IDLE;
        end
        ST_FLUSH: begin
          sweep_q <= sweep_q + set_t'(1);
          if (sweep_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_miss_fills_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (fill_req && fill_addr == {$past(req_addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}));

  p_fill_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> fill_req);

  p_miss_resp_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(fill_ack));

  p_stall_in_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  p_sweep_starts_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_busy) |-> (clr_set == '0));

  p_sweep_ends_at_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> ($past(clr_set) == set_t'(SETS - 1)));

  p_flush_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);
endmodule

// File: rtl/l1tag_lookup.sv
module l1tag_lookup
  import l1tag_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    req_ready,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [WAY_W-1:0]        resp_way,
  output logic                    fill_req,
  output logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_ack,
  input  logic                    flush,
  output logic                    flush_busy
);
  set_t   look_set;
  tag_t   look_tag;
  wmask_t hit_vec, set_valid;
  logic   hit_any;
  way_t   hit_way, victim;
  logic   wr_en, clr_en, touch_en;
  set_t   wr_set, clr_set, touch_set;
  way_t   wr_way, touch_way;
  tag_t   wr_tag;

  assign look_set = addr_set(req_addr);
  assign look_tag = addr_tag(req_addr);
  assign hit_any  = |hit_vec;
  assign hit_way  = first_one(hit_vec);

  l1tag_store u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_set(look_set), .rd_tag(look_tag),
    .hit_vec(hit_vec), .set_valid(set_valid),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .clr_en(clr_en), .clr_set(clr_set)
  );

  l1tag_lru u_lru (
    .clk(clk), .rst_n(rst_n),
    .look_set(look_set), .look_valid(set_valid), .victim(victim),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
  );

  l1tag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .hit_any(hit_any), .hit_way(hit_way), .victim(victim),
    .flush(flush), .flush_busy(flush_busy),
    .fill_ack(fill_ack), .fill_req(fill_req), .fill_addr(fill_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .clr_en(clr_en), .clr_set(clr_set),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
  );

  p_victim_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit_any && !(&set_valid)) |-> !set_valid[victim]);

  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit_any) |=> (resp_valid && resp_hit && resp_way == $past(hit_way)));
endmodule

// File: tb/test_l1tag_lookup.sv
module test_l1tag_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        req_ready, resp_valid, resp_hit, fill_req, flush_busy;
  logic [2:0]  resp_way;
  logic [35:0] fill_addr;
  logic        fill_ack = 1'b0;
  logic        flush = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model: tags, valid bits and last-use stamps
  logic [23:0] m_tag [64][8];
  bit          m_val [64][8];
  int          m_ts  [64][8];
  int          tick = 0;

  l1tag_lookup i_l1tag_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_ack(fill_ack), .flush(flush), .flush_busy(flush_busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(logic [23:0] t, int s, int off);
    return {t, 6'(s), 6'(off)};
  endfunction

  function automatic int pick_victim(int s);
    int best;
    best = 0;
    for (int w = 0; w < 8; w++) if (!m_val[s][w]) return w;
    for (int w = 1; w < 8; w++) if (m_ts[s][w] < m_ts[s][best]) best = w;
    return best;
  endfunction

  // one access; hit or miss decided by the model; entered just after a negedge
  task automatic access(input logic [35:0] a, input string rq);
    int s, hw, v;
    logic [23:0] t;
    s  = int'(a[11:6]);
    t  = a[35:12];
    hw = -1;
    for (int w = 0; w < 8; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    chk(req_ready == 1'b1, rq, "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (hw >= 0) begin
      chk(resp_valid == 1'b1, rq, "hit resp_valid", resp_valid, 1);
      chk(resp_hit == 1'b1, rq, "resp_hit", resp_hit, 1);
      chk(int'(resp_way) == hw, rq, "hit way", resp_way, hw);
      chk(fill_req == 1'b0, rq, "no fill on hit", fill_req, 0);
      tick++;
      m_ts[s][hw] = tick;
    end else begin
      v = pick_victim(s);
      chk(resp_valid == 1'b0, rq, "no resp before fill", resp_valid, 0);
      chk(fill_req == 1'b1, rq, "fill_req after miss", fill_req, 1);
      chk(fill_addr == {a[35:6], 6'b0}, "R1", "line-aligned fill_addr", fill_addr, {a[35:6], 6'b0});
      req_valid = 1'b1;               // probe that must stay blocked
      req_addr  = a ^ 36'h8000_0000;
      repeat (3) begin
        @(negedge clk);
        chk(fill_req == 1'b1, "R3", "fill_req held", fill_req, 1);
        chk(req_ready == 1'b0, "R4", "ready low while miss pending", req_ready, 0);
        chk(resp_valid == 1'b0, "R4", "no resp while pending", resp_valid, 0);
      end
      req_valid = 1'b0;
      fill_ack  = 1'b1;
      @(negedge clk);
      fill_ack = 1'b0;
      chk(resp_valid == 1'b1, rq, "miss resp_valid", resp_valid, 1);
      chk(resp_hit == 1'b0, rq, "miss resp_hit", resp_hit, 0);
      chk(int'(resp_way) == v, rq, "victim way", resp_way, v);
      chk(fill_req == 1'b0, "R3", "fill_req drops", fill_req, 0);
      chk(req_ready == 1'b1, "R4", "ready back after fill", req_ready, 1);
      m_val[s][v] = 1;
      m_tag[s][v] = t;
      tick++;
      m_ts[s][v] = tick;
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
    chk(resp_valid == 1'b0, "R10", "reset resp_valid", resp_valid, 0);
    chk(fill_req == 1'b0, "R10", "reset fill_req", fill_req, 0);
    chk(flush_busy == 1'b0, "R10", "reset flush_busy", flush_busy, 0);
    access(mk(24'h00_0777, 7, 0), "R10");   // empty after reset: must miss
  endtask

  task automatic t_cold_then_hit();
    access(mk(24'hABC123, 3, 17), "R3");
    access(mk(24'hABC123, 3, 63), "R1");   // other offset, same line: hit
    access(mk(24'hABC123, 3, 0),  "R2");
    access(mk(24'hABC124, 3, 0),  "R2");   // neighbour tag: miss
  endtask

  task automatic t_page_sweep();
    for (int i = 0; i < 64; i++) access(mk(24'h05_5AA0, i, 8), "R5");
    for (int i = 0; i < 64; i++) access(mk(24'h05_5AA0, i, 40), "R5");
  endtask

  task automatic t_invalid_first();
    access(mk(24'h11_0001, 9, 0), "R6");
    access(mk(24'h11_0002, 9, 0), "R6");
  endtask

  task automatic t_lru();
    for (int k = 0; k < 8; k++) access(mk(24'h20_0000 + 24'(k), 40, 0), "R7");
    for (int k = 0; k < 8; k++)
      if (k != 5) access(mk(24'h20_0000 + 24'(k), 40, 4), "R7");
    access(mk(24'h20_0100, 40, 0), "R7");    // evicts least recent line
    access(mk(24'h20_0005, 40, 0), "R7");    // evicted tag misses again
    access(mk(24'h20_0100, 40, 0), "R7");
  endtask

  task automatic t_flush();
    int n;
    flush     = 1'b1;
    req_valid = 1'b1;                       // same-cycle request must lose
    req_addr  = mk(24'hABC123, 3, 0);
    @(negedge clk);
    flush     = 1'b0;
    req_valid = 1'b0;
    chk(resp_valid == 1'b0, "R9", "request beside flush not served", resp_valid, 0);
    chk(flush_busy == 1'b1, "R8", "flush_busy rises", flush_busy, 1);
    n = 0;
    while (flush_busy && n < 200) begin
      chk(req_ready == 1'b0, "R8", "ready low during flush", req_ready, 0);
      n++;
      @(negedge clk);
    end
    chk(n == 64, "R8", "flush length", n, 64);
    chk(resp_valid == 1'b0, "R9", "no late response", resp_valid, 0);
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 8; w++) m_val[s][w] = 0;
    access(mk(24'hABC123, 3, 0), "R8");     // stale tag, invalid: miss
    access(mk(24'h05_5AA0, 63, 0), "R8");
    access(mk(24'h20_0100, 40, 0), "R6");   // way 0 despite old recency
    access(mk(24'hABC123, 3, 5), "R2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 8; w++) begin
        m_val[s][w] = 0;
        m_tag[s][w] = '0;
        m_ts[s][w]  = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_then_hit();
    t_invalid_first();
    t_page_sweep();
    t_lru();
    t_flush();
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    finish_run();
  end
endmodule